// File: doc/BRIEF.md
# Legacy Monochrome/VGA Cycle Router

This block sits beside a graphics-attached PCI Express port and decides, for each processor-initiated memory or I/O request, whether the request is forwarded to that port or stays on the internal backbone. The decision depends on several inputs. A small control byte holds two settings: a DRAM hole enable and a flag that says a monochrome display adapter lives elsewhere in the system. The port supplies its VGA-enable, memory-enable and I/O-enable bits and its I/O base/limit window. The block also flags memory requests that land in the 15–16 MB DRAM hole.

Requests arrive as a valid pulse with a type bit, an address and, for I/O, a byte-lane mask over an aligned dword. The decision is registered and appears one clock later with its own valid strobe. The control byte is written through a simple write strobe. A lock input freezes the hole-enable bit, but the monochrome flag stays writable.

Top module: `lgcy_cycle_router`

## Requirements
- R1: After reset the control byte reads 00h, route_valid_o and route_fwd_o are 0, and bits 6:4 and 2:0 of cfg_rdata_o always read 0.
- R2: A write with cfg_we_i updates bit 7 (hole enable) and bit 3 (monochrome present) from cfg_wdata_i on the next clock. While lock_i is 1, bit 7 keeps its value and bit 3 is still written.
- R3: A memory request to 0xF00000–0xFFFFFF with hole enable set gives hole_hit_o=1. The flag is 0 when hole enable is clear, when the address is outside that range, and for every I/O request.
- R4: With vga_en_i=0, no request is forwarded.
- R5: With vga_en_i=1 and monochrome present clear, memory 0xA0000–0xBFFFF is forwarded, including 0xB0000–0xB7FFF. I/O bytes 0x3B0–0x3BB and 0x3C0–0x3DF are forwarded.
- R6: With vga_en_i=1 and monochrome present set, memory 0xB0000–0xB7FFF stays on the backbone. Any I/O request with an enabled byte at 0x3B4, 0x3B5, 0x3B8, 0x3B9, 0x3BA or 0x3BF stays, even if its other bytes are VGA. All other VGA resources are forwarded.
- R7: I/O decoding ignores address bits 15:10, so every alias of a monochrome or VGA port decodes like the base port.
- R8: A byte at 0x3BC–0x3BF (alias-decoded) is forwarded only if its full 16-bit address is inside [io_base_i, io_limit_i].
- R9: Memory requests are forwarded only if mem_en_i=1. I/O requests are forwarded only if io_en_i=1.
- R10: cfg_err_o is 1 exactly when monochrome present is set and vga_en_i=0.
- R11: A request sampled at a clock edge yields route_valid_o=1 with its decision after that edge. A cycle without req_valid_i yields route_valid_o=0, route_fwd_o=0 and hole_hit_o=0.
- R12: An I/O request is forwarded only if at least one lane of req_be_i is set and every enabled byte is claimed. Lane k of req_be_i addresses byte {req_addr_i[15:2], k}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control byte write strobe |
| cfg_wdata_i | input | 8 | Control byte write data |
| lock_i | input | 1 | Freezes the hole-enable bit |
| cfg_rdata_o | output | 8 | Control byte read value |
| vga_en_i | input | 1 | Port VGA enable |
| mem_en_i | input | 1 | Port memory access enable |
| io_en_i | input | 1 | Port I/O access enable |
| io_base_i | input | 16 | Port I/O window base (inclusive) |
| io_limit_i | input | 16 | Port I/O window limit (inclusive) |
| req_valid_i | input | 1 | Request strobe |
| req_is_io_i | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr_i | input | 32 | Request address (I/O uses bits 15:2) |
| req_be_i | input | 4 | I/O byte-lane enables |
| route_valid_o | output | 1 | Decision valid |
| route_fwd_o | output | 1 | 1 = forward to port, 0 = backbone |
| hole_hit_o | output | 1 | Request hit the DRAM hole |
| cfg_err_o | output | 1 | Illegal monochrome/VGA combination |

## Verification
The hardest case to reach is a mixed-span I/O request. A dword can mix claimed VGA bytes with an unclaimed monochrome byte or with a 0x3BC–0x3BF byte outside the window, and the route flips on a single lane. The bench drives byte-lane masks that straddle those boundaries at aliased upper address bits. It also moves the I/O window so that it splits a dword. These runs go with the monochrome flag in both states, so each lane's contribution can be seen at route_fwd_o.

// File: rtl/lr_pkg.sv
package lr_pkg;
  localparam int unsigned ALIAS_W = 10;
  localparam int unsigned CFG_W   = 8;
  localparam int unsigned HEN_BIT = 7;
  localparam int unsigned MDP_BIT = 3;
  localparam logic [CFG_W-1:0] CFG_WMASK = 8'h88;

  localparam logic [23:0] VGA_MEM_LO  = 24'h0A_0000;
  localparam logic [23:0] VGA_MEM_HI  = 24'h0B_FFFF;
  localparam logic [23:0] MONO_MEM_LO = 24'h0B_0000;
  localparam logic [23:0] MONO_MEM_HI = 24'h0B_7FFF;
  localparam logic [23:0] HOLE_LO     = 24'hF0_0000;
  localparam logic [23:0] HOLE_HI     = 24'hFF_FFFF;

  function automatic logic mono_port(input logic [ALIAS_W-1:0] a);
    case (a)
      10'h3B4, 10'h3B5, 10'h3B8, 10'h3B9, 10'h3BA, 10'h3BF: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic vga_port(input logic [ALIAS_W-1:0] a);
    return ((a >= 10'h3B0) && (a <= 10'h3BB)) || ((a >= 10'h3C0) && (a <= 10'h3DF));
  endfunction

  function automatic logic win_port(input logic [ALIAS_W-1:0] a);
    return (a >= 10'h3BC) && (a <= 10'h3BF);
  endfunction
endpackage

// File: rtl/lr_ctrl_reg.sv
module lr_ctrl_reg
  import lr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             lock_i,
  output logic [CFG_W-1:0] q_o,
  output logic             hen_o,
  output logic             mono_o
);
  logic [CFG_W-1:0] q, nxt;

  always_comb begin
    nxt = q;
    if (we_i) begin
      nxt = wdata_i & CFG_WMASK;
      if (lock_i) nxt[HEN_BIT] = q[HEN_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign q_o    = q;
  assign hen_o  = q[HEN_BIT];
  assign mono_o = q[MDP_BIT];
endmodule

// File: rtl/lr_mem_decode.sv
module lr_mem_decode
  import lr_pkg::*;
#(
  parameter int unsigned MEM_W = 32
) (
  input  logic [MEM_W-1:0] addr_i,
  input  logic             hen_i,
  output logic             vga_o,
  output logic             mono_o,
  output logic             hole_o
);
  localparam logic [MEM_W-1:0] V_LO = MEM_W'(VGA_MEM_LO);
  localparam logic [MEM_W-1:0] V_HI = MEM_W'(VGA_MEM_HI);
  localparam logic [MEM_W-1:0] M_LO = MEM_W'(MONO_MEM_LO);
  localparam logic [MEM_W-1:0] M_HI = MEM_W'(MONO_MEM_HI);
  localparam logic [MEM_W-1:0] H_LO = MEM_W'(HOLE_LO);
  localparam logic [MEM_W-1:0] H_HI = MEM_W'(HOLE_HI);

  assign vga_o  = (addr_i >= V_LO) && (addr_i <= V_HI);
  assign mono_o = (addr_i >= M_LO) && (addr_i <= M_HI);
  assign hole_o = hen_i && (addr_i >= H_LO) && (addr_i <= H_HI);
endmodule

// File: rtl/lr_io_decode.sv
module lr_io_decode
  import lr_pkg::*;
#(
  parameter int unsigned IO_W  = 16,
  parameter int unsigned LANES = 4
) (
  input  logic [IO_W-1:$clog2(LANES)] addr_hi_i,
  input  logic [LANES-1:0]            be_i,
  input  logic [IO_W-1:0]             base_i,
  input  logic [IO_W-1:0]             limit_i,
  output logic                        any_lane_o,
  output logic                        any_mono_o,
  output logic                        all_claim_o
);
  localparam int unsigned LANE_W = $clog2(LANES);

  logic [LANES-1:0] mono_l, claim_l;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [IO_W-1:0]    byte_a;
    logic [ALIAS_W-1:0] al;
    logic               in_win;
    assign byte_a     = {addr_hi_i, LANE_W'(k)};
    assign al         = byte_a[ALIAS_W-1:0];
    assign in_win     = (byte_a >= base_i) && (byte_a <= limit_i);
    assign mono_l[k]  = be_i[k] && mono_port(al);
    // a disabled lane never blocks the claim
    assign claim_l[k] = !be_i[k] || vga_port(al) || (win_port(al) && in_win);
  end

  assign any_lane_o  = |be_i;
  assign any_mono_o  = |mono_l;
  assign all_claim_o = &claim_l;
endmodule

// File: rtl/lgcy_cycle_router.sv
module lgcy_cycle_router
  import lr_pkg::*;
#(
  parameter int unsigned MEM_W = 32,
  parameter int unsigned IO_W  = 16,
  parameter int unsigned LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [7:0]       cfg_wdata_i,
  input  logic             lock_i,
  output logic [7:0]       cfg_rdata_o,
  input  logic             vga_en_i,
  input  logic             mem_en_i,
  input  logic             io_en_i,
  input  logic [IO_W-1:0]  io_base_i,
  input  logic [IO_W-1:0]  io_limit_i,
  input  logic             req_valid_i,
  input  logic             req_is_io_i,
  input  logic [MEM_W-1:0] req_addr_i,
  input  logic [LANES-1:0] req_be_i,
  output logic             route_valid_o,
  output logic             route_fwd_o,
  output logic             hole_hit_o,
  output logic             cfg_err_o
);
  localparam int unsigned LANE_W = $clog2(LANES);

  logic hen, mono;
  logic m_vga, m_mono, m_hole;
  logic i_any, i_mono, i_claim;
  logic mem_fwd, io_fwd, fwd_d, hole_d;
  logic vld_q, fwd_q, hole_q;

  lr_ctrl_reg i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .lock_i  (lock_i),
    .q_o     (cfg_rdata_o),
    .hen_o   (hen),
    .mono_o  (mono)
  );

  lr_mem_decode #(.MEM_W(MEM_W)) i_mem (
    .addr_i (req_addr_i),
    .hen_i  (hen),
    .vga_o  (m_vga),
    .mono_o (m_mono),
    .hole_o (m_hole)
  );

  lr_io_decode #(.IO_W(IO_W), .LANES(LANES)) i_io (
    .addr_hi_i   (req_addr_i[IO_W-1:LANE_W]),
    .be_i        (req_be_i),
    .base_i      (io_base_i),
    .limit_i     (io_limit_i),
    .any_lane_o  (i_any),
    .any_mono_o  (i_mono),
    .all_claim_o (i_claim)
  );

  // monochrome present removes the monochrome resources from the claim
  assign mem_fwd = vga_en_i && mem_en_i && m_vga && !(mono && m_mono);
  assign io_fwd  = vga_en_i && io_en_i && i_any && i_claim && !(mono && i_mono);
  assign fwd_d   = req_valid_i && (req_is_io_i ? io_fwd : mem_fwd);
  assign hole_d  = req_valid_i && !req_is_io_i && m_hole;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      fwd_q  <= 1'b0;
      hole_q <= 1'b0;
    end else begin
      vld_q  <= req_valid_i;
      fwd_q  <= fwd_d;
      hole_q <= hole_d;
    end
  end

  assign route_valid_o = vld_q;
  assign route_fwd_o   = fwd_q;
  assign hole_hit_o    = hole_q;
  assign cfg_err_o     = mono && !vga_en_i;
endmodule

// File: rtl/lr_router_chk.sv
module lr_router_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_we_i,
  input logic [7:0] cfg_wdata_i,
  input logic       lock_i,
  input logic [7:0] cfg_rdata_o,
  input logic       vga_en_i,
  input logic       mem_en_i,
  input logic       io_en_i,
  input logic       req_valid_i,
  input logic       req_is_io_i,
  input logic       route_valid_o,
  input logic       route_fwd_o,
  input logic       hole_hit_o,
  input logic       cfg_err_o
);
  a_r1_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[6:4] == 3'b0) && (cfg_rdata_o[2:0] == 3'b0));

  a_r2_lock_hen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && lock_i) |=> $stable(cfg_rdata_o[7]));

  a_r2_write_mono: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (cfg_rdata_o[3] == $past(cfg_wdata_i[3])));

  a_r3_no_io_hole: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_is_io_i) |=> !hole_hit_o);

  a_r4_vga_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vga_en_i |=> !route_fwd_o);

  a_r9_mem_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_is_io_i && !mem_en_i) |=> !route_fwd_o);

  a_r9_io_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_is_io_i && !io_en_i) |=> !route_fwd_o);

  a_r10_err_vga: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!vga_en_i && cfg_rdata_o[3]));

  a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!route_valid_o && !route_fwd_o && !hole_hit_o));

  a_r11_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> route_valid_o);
endmodule

bind lgcy_cycle_router lr_router_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_we_i      (cfg_we_i),
  .cfg_wdata_i   (cfg_wdata_i),
  .lock_i        (lock_i),
  .cfg_rdata_o   (cfg_rdata_o),
  .vga_en_i      (vga_en_i),
  .mem_en_i      (mem_en_i),
  .io_en_i       (io_en_i),
  .req_valid_i   (req_valid_i),
  .req_is_io_i   (req_is_io_i),
  .route_valid_o (route_valid_o),
  .route_fwd_o   (route_fwd_o),
  .hole_hit_o    (hole_hit_o),
  .cfg_err_o     (cfg_err_o)
);

// File: tb/test_lgcy_cycle_router.sv
module test_lgcy_cycle_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        lock = 1'b0;
  logic [7:0]  cfg_rdata;
  logic        vga_en = 1'b0, mem_en = 1'b0, io_en = 1'b0;
  logic [15:0] io_base = '0, io_limit = '0;
  logic        req_valid = 1'b0, req_is_io = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic        route_valid, route_fwd, hole_hit, cfg_err;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  lgcy_cycle_router i_lgcy_cycle_router (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .lock_i(lock), .cfg_rdata_o(cfg_rdata), .vga_en_i(vga_en), .mem_en_i(mem_en),
    .io_en_i(io_en), .io_base_i(io_base), .io_limit_i(io_limit),
    .req_valid_i(req_valid), .req_is_io_i(req_is_io), .req_addr_i(req_addr),
    .req_be_i(req_be), .route_valid_o(route_valid), .route_fwd_o(route_fwd),
    .hole_hit_o(hole_hit), .cfg_err_o(cfg_err)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rq(input logic io, input logic [31:0] a, input logic [3:0] be,
                    input logic exp_fwd, input logic exp_hole, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_is_io = io; req_addr = a; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid R11"}, {7'b0, route_valid}, 8'h01);
    chk({tag, " fwd"}, {7'b0, route_fwd}, {7'b0, exp_fwd});
    chk({tag, " hole"}, {7'b0, hole_hit}, {7'b0, exp_hole});
  endtask

  task automatic t_reset;
    chk("R1 rdata reset", cfg_rdata, 8'h00);
    chk("R1 valid reset", {7'b0, route_valid}, 8'h00);
    chk("R1 fwd reset", {7'b0, route_fwd}, 8'h00);
  endtask

  task automatic t_cfg;
    wr_cfg(8'h88);
    chk("R2 write 88", cfg_rdata, 8'h88);
    wr_cfg(8'h7F);
    chk("R1 reserved masked", cfg_rdata, 8'h08);
    wr_cfg(8'h80);
    lock = 1'b1;
    wr_cfg(8'h08);
    chk("R2 lock keeps hen, mono written", cfg_rdata, 8'h88);
    wr_cfg(8'h00);
    chk("R2 lock clears mono only", cfg_rdata, 8'h80);
    lock = 1'b0;
    wr_cfg(8'h00);
    chk("R2 unlock write", cfg_rdata, 8'h00);
  endtask

  task automatic t_err;
    vga_en = 1'b0;
    wr_cfg(8'h08);
    #1 chk("R10 illegal combo", {7'b0, cfg_err}, 8'h01);
    vga_en = 1'b1;
    #1 chk("R10 legal vga+mono", {7'b0, cfg_err}, 8'h00);
    wr_cfg(8'h00);
    vga_en = 1'b0;
    #1 chk("R10 legal none", {7'b0, cfg_err}, 8'h00);
  endtask

  task automatic t_hole;
    wr_cfg(8'h80);
    rq(1'b0, 32'h00F0_0000, 4'h0, 1'b0, 1'b1, "R3 hole low");
    rq(1'b0, 32'h00FF_FFFF, 4'h0, 1'b0, 1'b1, "R3 hole high");
    rq(1'b0, 32'h00EF_FFFF, 4'h0, 1'b0, 1'b0, "R3 below hole");
    rq(1'b0, 32'h0100_0000, 4'h0, 1'b0, 1'b0, "R3 above hole");
    rq(1'b1, 32'h0000_0000, 4'hF, 1'b0, 1'b0, "R3 io no hole");
    wr_cfg(8'h00);
    rq(1'b0, 32'h00F0_0000, 4'h0, 1'b0, 1'b0, "R3 hole disabled");
  endtask

  task automatic t_vga_off;
    vga_en = 1'b0; mem_en = 1'b1; io_en = 1'b1;
    rq(1'b0, 32'h000A_0000, 4'h0, 1'b0, 1'b0, "R4 mem vga off");
    rq(1'b1, 32'h0000_03C0, 4'hF, 1'b0, 1'b0, "R4 io vga off");
    rq(1'b1, 32'h0000_03B4, 4'h1, 1'b0, 1'b0, "R4 mono io vga off");
  endtask

  task automatic t_vga_only;
    vga_en = 1'b1; wr_cfg(8'h00);
    rq(1'b0, 32'h000A_0000, 4'h0, 1'b1, 1'b0, "R5 mem A0000");
    rq(1'b0, 32'h000B_0000, 4'h0, 1'b1, 1'b0, "R5 mem B0000");
    rq(1'b0, 32'h000B_FFFF, 4'h0, 1'b1, 1'b0, "R5 mem BFFFF");
    rq(1'b0, 32'h000C_0000, 4'h0, 1'b0, 1'b0, "R5 mem C0000");
    rq(1'b0, 32'h0009_FFFF, 4'h0, 1'b0, 1'b0, "R5 mem 9FFFF");
    rq(1'b1, 32'h0000_03B4, 4'h1, 1'b1, 1'b0, "R5 io 3B4");
    rq(1'b1, 32'h0000_03DC, 4'hF, 1'b1, 1'b0, "R5 io 3DC-3DF");
    rq(1'b1, 32'h0000_03E0, 4'h1, 1'b0, 1'b0, "R5 io 3E0");
    rq(1'b1, 32'h0000_FBB4, 4'h1, 1'b1, 1'b0, "R7 alias FBB4 no mono");
  endtask

  task automatic t_gate;
    vga_en = 1'b1; wr_cfg(8'h00);
    mem_en = 1'b0;
    rq(1'b0, 32'h000A_0000, 4'h0, 1'b0, 1'b0, "R9 mem gated");
    rq(1'b1, 32'h0000_03C0, 4'hF, 1'b1, 1'b0, "R9 io open mem off");
    mem_en = 1'b1; io_en = 1'b0;
    rq(1'b1, 32'h0000_03C0, 4'hF, 1'b0, 1'b0, "R9 io gated");
    rq(1'b0, 32'h000A_0000, 4'h0, 1'b1, 1'b0, "R9 mem open io off");
    io_en = 1'b1;
  endtask

  task automatic t_mono;
    vga_en = 1'b1; wr_cfg(8'h08);
    rq(1'b0, 32'h000B_0000, 4'h0, 1'b0, 1'b0, "R6 mem B0000");
    rq(1'b0, 32'h000B_7FFF, 4'h0, 1'b0, 1'b0, "R6 mem B7FFF");
    rq(1'b0, 32'h000B_8000, 4'h0, 1'b1, 1'b0, "R6 mem B8000");
    rq(1'b0, 32'h000A_0000, 4'h0, 1'b1, 1'b0, "R6 mem A0000");
    rq(1'b1, 32'h0000_03B4, 4'h1, 1'b0, 1'b0, "R6 io 3B4");
    rq(1'b1, 32'h0000_03B0, 4'hF, 1'b1, 1'b0, "R6 io 3B0-3B3");
    rq(1'b1, 32'h0000_03B4, 4'h4, 1'b1, 1'b0, "R6 io 3B6");
    rq(1'b1, 32'h0000_03B4, 4'hC, 1'b1, 1'b0, "R6 io 3B6-3B7");
    rq(1'b1, 32'h0000_03B4, 4'hE, 1'b0, 1'b0, "R6 R12 mixed 3B5-3B7");
    rq(1'b1, 32'h0000_03B8, 4'h8, 1'b1, 1'b0, "R6 io 3BB");
    rq(1'b1, 32'h0000_7BB4, 4'h1, 1'b0, 1'b0, "R7 alias 7BB4 mono");
    rq(1'b1, 32'h0000_7BC0, 4'hF, 1'b1, 1'b0, "R7 alias 7BC0 vga");
    rq(1'b1, 32'h0000_FFB8, 4'h2, 1'b0, 1'b0, "R7 alias FFB9 mono");
    wr_cfg(8'h00);
  endtask

  task automatic t_window;
    vga_en = 1'b1; wr_cfg(8'h00);
    io_base = 16'h03BC; io_limit = 16'h03BF;
    rq(1'b1, 32'h0000_03BC, 4'h1, 1'b1, 1'b0, "R8 3BC in window");
    rq(1'b1, 32'h0000_03BC, 4'h8, 1'b1, 1'b0, "R8 3BF in window");
    rq(1'b1, 32'h0000_07BC, 4'h1, 1'b0, 1'b0, "R8 alias 7BC outside");
    io_base = 16'h1000; io_limit = 16'h1FFF;
    rq(1'b1, 32'h0000_03BC, 4'h1, 1'b0, 1'b0, "R8 3BC outside");
    rq(1'b1, 32'h0000_13BC, 4'h1, 1'b1, 1'b0, "R8 alias 13BC inside");
    io_base = 16'h03BC; io_limit = 16'h03BD;
    rq(1'b1, 32'h0000_03BC, 4'h3, 1'b1, 1'b0, "R12 split window low");
    rq(1'b1, 32'h0000_03BC, 4'hF, 1'b0, 1'b0, "R12 split window all");
    rq(1'b1, 32'h0000_03C0, 4'h0, 1'b0, 1'b0, "R12 no lanes");
    vga_en = 1'b0; io_base = 16'h03BC; io_limit = 16'h03BF;
    rq(1'b1, 32'h0000_03BC, 4'h1, 1'b0, 1'b0, "R8 R4 window vga off");
  endtask

  task automatic t_idle;
    @(negedge clk);
    @(negedge clk);
    chk("R11 idle valid", {7'b0, route_valid}, 8'h00);
    chk("R11 idle fwd", {7'b0, route_fwd}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R11 watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_cfg();
    t_err();
    t_hole();
    t_vga_off();
    t_vga_only();
    t_gate();
    t_mono();
    t_window();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule